// File: doc/BRIEF.md
# System Management Interrupt Capture

This block sits between an asynchronous, active-low system management interrupt pin and a processor core's instruction sequencer. It brings the pin into the core clock domain, turns each qualifying falling edge into a single request, and then decides on which clock the sequencer may enter the handler. Software cannot mask the request. The block has no interrupt-enable input at all.

A request is accepted only on an instruction-boundary strobe that does not fall inside a locked bus sequence. It wins against a simultaneous NMI request. Once a request is granted, further edges are masked until the resume-from-handler strobe, with room for exactly one stored request. That stored request is granted at the first boundary after resume, which gives back-to-back handlers. Edges are disregarded while soft reset is active and for a short settling window after it drops. The edge detector re-arms only after the pin has stayed inactive for a minimum run of clocks.

The sequencer FSM has four states. `SQ_IDLE` means nothing is pending. `SQ_WAIT_BND` means a request waits for a boundary. `SQ_IN_HANDLER` means the handler is running with no stored request. `SQ_IN_HANDLER_PEND` means the handler is running with one stored request. The transitions are:

- `SQ_IDLE` to `SQ_WAIT_BND` on an edge.
- `SQ_WAIT_BND` to `SQ_IN_HANDLER` on a grant.
- `SQ_WAIT_BND` to `SQ_IN_HANDLER_PEND` on a grant that coincides with an edge.
- `SQ_IN_HANDLER` to `SQ_IN_HANDLER_PEND` on an edge.
- `SQ_IN_HANDLER` to `SQ_IDLE` on resume.
- `SQ_IN_HANDLER` to `SQ_WAIT_BND` on resume together with an edge.
- `SQ_IN_HANDLER_PEND` to `SQ_WAIT_BND` on resume.

Top module: `smi_capture`

## Requirements
- R1: A falling edge of `smi_pin_n` (low = active) produces exactly one `take_smi` pulse, however long the pin stays low. The pin is sampled on two synchronizer flops, and the edge is evaluated one clock later. A pin that goes low in cycle i is first grantable in cycle i+3.
- R2: An edge is recognized only if the synchronized pin was high for at least 4 consecutive clocks just before it. An edge after a shorter high run is ignored.
- R3: `take_smi` and `take_nmi` are asserted only in a cycle where `insn_boundary` = 1 and `bus_locked` = 0. A waiting request is held until such a cycle arrives.
- R4: When an SMI request is waiting and `nmi_req` = 1 at a grantable boundary, only `take_smi` is asserted. `take_nmi` is asserted at a grantable boundary when no SMI request is waiting, including while a handler runs.
- R5: After a grant, no further `take_smi` occurs until `rsm_done` has been seen.
- R6: While the handler runs, any number of edges leaves at most one stored request. After resume, exactly one further grant follows.
- R7: A stored request is granted at the first grantable boundary after `rsm_done`.
- R8: Edges evaluated while `soft_reset` = 1, or in the first two clocks after it returns to 0, are ignored. An edge evaluated in the third clock is recognized.
- R9: `take_smi` is a one-clock pulse. It is never high on two consecutive clocks, and it is never high together with `take_nmi`.
- R10: After hard reset, both grant outputs are 0 and no request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| smi_pin_n | input | 1 | Asynchronous interrupt pin, active low |
| insn_boundary | input | 1 | Instruction-boundary strobe from the sequencer |
| bus_locked | input | 1 | High while a locked bus sequence is in progress |
| rsm_done | input | 1 | Pulse when the resume-from-handler instruction completes |
| soft_reset | input | 1 | Soft reset level |
| nmi_req | input | 1 | NMI request level |
| take_smi | output | 1 | Grant: enter the system management handler now |
| take_nmi | output | 1 | Grant: enter the NMI handler now |

## Verification
The pin is driven with four patterns:

- A single long low level, which shows that one edge yields one grant.
- A short high gap before a second fall, which shows whether the re-arm window is enforced or an edge is counted too early.
- Repeated falls during a handler, which separate the stored slot from a mask that drops edges or a queue that keeps them all.
- Falls placed against soft reset release, which mark the exact clock where the blanking window ends.

Boundaries are offered early, inside locked sequences and together with NMI, to tell waiting from granting and to check which grant wins.

// File: rtl/smi_pkg.sv
package smi_pkg;

    // Sequencer states of the capture block
    typedef enum logic [1:0] {
        SQ_IDLE            = 2'd0,
        SQ_WAIT_BND        = 2'd1,
        SQ_IN_HANDLER      = 2'd2,
        SQ_IN_HANDLER_PEND = 2'd3
    } sq_state_t;

    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_REARM_CLKS  = 4;
    localparam int unsigned DEF_BLANK_CLKS  = 2;

endpackage

// File: rtl/smi_sync_edge.sv
// Synchronizer, previous-sample register and re-arm counter.
module smi_sync_edge #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REARM_CLKS  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_seen
);
    localparam int unsigned CW = $clog2(REARM_CLKS + 1);
    localparam logic [CW-1:0] CMAX = CW'(REARM_CLKS);

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;
    logic [CW-1:0]          high_run;
    logic                   synced;

    // synchronizer chain, one flop per stage, idle level high
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= pin_n;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign synced = chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= 1'b1;
            high_run <= '0;
        end else begin
            prev_q <= synced;
            if (!synced)
                high_run <= '0;
            else if (high_run != CMAX)
                high_run <= high_run + 1'b1;
        end
    end

    assign fall_seen = prev_q && !synced && (high_run == CMAX);

endmodule

// File: rtl/smi_blank.sv
// Suppresses edges during soft reset and a settling window after it.
module smi_blank #(
    parameter int unsigned BLANK_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_reset,
    output logic edge_open
);
    localparam int unsigned BW = $clog2(BLANK_CLKS + 1);
    localparam logic [BW-1:0] BLOAD = BW'(BLANK_CLKS);

    logic [BW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (soft_reset)
            left_q <= BLOAD;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign edge_open = !soft_reset && (left_q == '0);

endmodule

// File: rtl/smi_seq.sv
// Request sequencer: waiting, masking, one stored slot, arbitration.
module smi_seq
    import smi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_ok,
    input  logic insn_boundary,
    input  logic bus_locked,
    input  logic rsm_done,
    input  logic nmi_req,
    output logic take_smi,
    output logic take_nmi
);
    sq_state_t state_q, state_d;
    logic      slot_open;
    logic      grant_now;

    assign slot_open = insn_boundary && !bus_locked;
    assign grant_now = (state_q == SQ_WAIT_BND) && slot_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (edge_ok) state_d = SQ_WAIT_BND;
            end
            SQ_WAIT_BND: begin
                if (grant_now)
                    state_d = edge_ok ? SQ_IN_HANDLER_PEND : SQ_IN_HANDLER;
            end
            SQ_IN_HANDLER: begin
                if (rsm_done)
                    state_d = edge_ok ? SQ_WAIT_BND : SQ_IDLE;
                else if (edge_ok)
                    state_d = SQ_IN_HANDLER_PEND;
            end
            SQ_IN_HANDLER_PEND: begin
                if (rsm_done) state_d = SQ_WAIT_BND;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        take_smi = grant_now;
        take_nmi = nmi_req && slot_open && (state_q != SQ_WAIT_BND);
    end

endmodule

// File: rtl/smi_capture.sv
module smi_capture
    import smi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned REARM_CLKS  = DEF_REARM_CLKS,
    parameter int unsigned BLANK_CLKS  = DEF_BLANK_CLKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smi_pin_n,
    input  logic insn_boundary,
    input  logic bus_locked,
    input  logic rsm_done,
    input  logic soft_reset,
    input  logic nmi_req,
    output logic take_smi,
    output logic take_nmi
);
    logic fall_seen;
    logic edge_open;
    logic edge_ok;

    smi_sync_edge #(
        .SYNC_STAGES (SYNC_STAGES),
        .REARM_CLKS  (REARM_CLKS)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (smi_pin_n),
        .fall_seen (fall_seen)
    );

    smi_blank #(
        .BLANK_CLKS (BLANK_CLKS)
    ) u_blank (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_reset (soft_reset),
        .edge_open  (edge_open)
    );

    assign edge_ok = fall_seen && edge_open;

    smi_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .edge_ok       (edge_ok),
        .insn_boundary (insn_boundary),
        .bus_locked    (bus_locked),
        .rsm_done      (rsm_done),
        .nmi_req       (nmi_req),
        .take_smi      (take_smi),
        .take_nmi      (take_nmi)
    );

endmodule

// File: rtl/smi_capture_chk.sv
module smi_capture_chk (
    input logic clk,
    input logic rst_n,
    input logic insn_boundary,
    input logic bus_locked,
    input logic rsm_done,
    input logic take_smi,
    input logic take_nmi
);
    logic in_smm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        in_smm <= 1'b0;
        else if (take_smi) in_smm <= 1'b1;
        else if (rsm_done) in_smm <= 1'b0;
    end

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_smi && take_nmi)); // R9

    AST_SMI_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_smi |-> (insn_boundary && !bus_locked)); // R3

    AST_NMI_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |-> (insn_boundary && !bus_locked)); // R3

    AST_SMI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        take_smi |=> !take_smi); // R9

    AST_MASKED_IN_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        in_smm |-> !take_smi); // R5

endmodule

bind smi_capture smi_capture_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .bus_locked    (bus_locked),
    .rsm_done      (rsm_done),
    .take_smi      (take_smi),
    .take_nmi      (take_nmi)
);

// File: tb/sim_smi_capture.sv
`timescale 1ns/1ps
module sim_smi_capture;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smi_pin_n = 1'b1;
    logic insn_boundary = 1'b0;
    logic bus_locked = 1'b0;
    logic rsm_done = 1'b0;
    logic soft_reset = 1'b0;
    logic nmi_req = 1'b0;
    logic take_smi;
    logic take_nmi;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk; // 125 MHz

    smi_capture u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .smi_pin_n     (smi_pin_n),
        .insn_boundary (insn_boundary),
        .bus_locked    (bus_locked),
        .rsm_done      (rsm_done),
        .soft_reset    (soft_reset),
        .nmi_req       (nmi_req),
        .take_smi      (take_smi),
        .take_nmi      (take_nmi)
    );

    // entry: {req tag, pin, boundary, locked, rsm, nmi, exp_smi, exp_nmi}
    localparam int NV = 42;
    localparam logic [10:0] VEC [NV] = '{
        {4'd10, 7'b1000000}, {4'd10, 7'b1000000}, {4'd10, 7'b1000000}, // R10 idle
        {4'd10, 7'b1000000}, {4'd10, 7'b1000000}, {4'd10, 7'b1000000},
        {4'd1,  7'b0000000}, {4'd1,  7'b0000000},                      // R1 fall
        {4'd3,  7'b0100000}, {4'd3,  7'b0110000},                      // R3 early, locked
        {4'd1,  7'b0100010}, {4'd9,  7'b0100000},                      // R1 grant, R9 pulse
        {4'd5,  7'b1001000}, {4'd1,  7'b1100000}, {4'd4,  7'b1100101}, // R5 resume, R4 nmi alone
        {4'd2,  7'b0000000}, {4'd2,  7'b1000000}, {4'd2,  7'b1100000}, // R2 short gap
        {4'd2,  7'b1100000}, {4'd2,  7'b1100000},
        {4'd2,  7'b0000000}, {4'd2,  7'b0000000},                      // R2 armed fall
        {4'd4,  7'b1100101}, {4'd4,  7'b1100110}, {4'd4,  7'b1100101}, // R4 priority
        {4'd6,  7'b1000000}, {4'd6,  7'b0000000}, {4'd6,  7'b1000000}, // R6 stored edge
        {4'd6,  7'b1000000}, {4'd5,  7'b1100000}, {4'd6,  7'b1000000},
        {4'd6,  7'b0000000}, {4'd6,  7'b1000000}, {4'd5,  7'b1100000}, // R6 extra edge dropped
        {4'd5,  7'b1100000}, {4'd7,  7'b1001000}, {4'd7,  7'b1100010}, // R7 back-to-back
        {4'd9,  7'b1100000}, {4'd6,  7'b1001000}, {4'd6,  7'b1100000},
        {4'd3,  7'b1110100}, {4'd3,  7'b1100101}                       // R3 nmi vs lock
    };

    task automatic apply(input logic p, input logic b, input logic l,
                         input logic r, input logic n, input logic s,
                         input logic es, input logic en, input int rq);
        @(negedge clk);
        smi_pin_n     = p;
        insn_boundary = b;
        bus_locked    = l;
        rsm_done      = r;
        nmi_req       = n;
        soft_reset    = s;
        #2;
        n_checks++;
        if (take_smi !== es || take_nmi !== en) begin
            n_fails++;
            $display("FAIL R%0d at %0t: take_smi=%b take_nmi=%b expected %b %b",
                     rq, $time, take_smi, take_nmi, es, en);
        end
    endtask

    initial begin
        #1_000_000;
        n_fails++;
        $display("FAIL watchdog expired: checks=%0d expected completion", n_checks);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R10: outputs quiet while in reset
        repeat (2) @(negedge clk);
        n_checks++;
        if (take_smi !== 1'b0 || take_nmi !== 1'b0) begin
            n_fails++;
            $display("FAIL R10 reset: take_smi=%b take_nmi=%b expected 0 0", take_smi, take_nmi);
        end
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], 1'b0,
                  VEC[i][1], VEC[i][0], int'(VEC[i][10:7]));
        end

        // R8: edge one clock after soft reset release is ignored
        for (int k = 0; k < 4; k++) apply(1, 0, 0, 0, 0, 0, 0, 0, 8);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 8);
        apply(1, 0, 0, 0, 0, 1, 0, 0, 8);
        apply(1, 0, 0, 0, 0, 0, 0, 0, 8);
        for (int k = 0; k < 4; k++) apply(1, 1, 0, 0, 0, 0, 0, 0, 8);
        // R8: edge on the third clock after release is recognized
        apply(1, 0, 0, 0, 0, 1, 0, 0, 8);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 8);
        apply(1, 0, 0, 0, 0, 0, 0, 0, 8);
        apply(1, 0, 0, 0, 0, 0, 0, 0, 8);
        apply(1, 1, 0, 0, 0, 0, 1, 0, 8);
        apply(1, 1, 0, 0, 0, 0, 0, 0, 5);
        apply(1, 0, 0, 1, 0, 0, 0, 0, 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule